// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes a stereo serial audio stream (bit clock, frame clock and data) and turns it into parallel samples. It runs on an oversampling system clock. The three serial lines are brought into that domain through synchroniser chains, and the chosen bit-clock edge becomes a one-cycle sampling tick. Four static control fields set the behaviour: framing style, frame-clock sense, bit-clock edge and word length.

Four framing styles are supported: I2S, left aligned, right aligned and a short-pulse framed mode in which both channels follow one pulse back to back. Whatever the incoming word length, each sample comes out as a 24-bit signed word. A one-cycle strobe and a channel flag go with it.

The control fields are expected to change only while reset is held.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_i` selects framing: 2'b00 right aligned, 2'b01 left aligned, 2'b10 I2S, 2'b11 pulse framed. In the first three, the effective frame level is `lrck_i ^ lr_pol_i`. Level 0 marks the left channel (`smp_right_o`=0) and level 1 the right channel (`smp_right_o`=1).
- R2: In I2S framing, the MSB is taken on the second sampling edge after a frame-level change. The slot's sample is delivered after the next frame-level change.
- R3: In left-aligned framing, the MSB is taken on the first sampling edge that sees the new frame level.
- R4: In right-aligned framing, the LSB is taken on the last sampling edge before the next frame-level change. `wlen_i`=2'b11 is treated as 24 bits in this framing.
- R5: In pulse framing, the frame starts on a sampling edge where `lrck_i` is 1 after having been 0. When `lr_pol_i`=0, the left MSB is taken one edge later; when `lr_pol_i`=1, it is taken two edges later. The right word follows the left LSB with no gap, and each word is delivered as soon as its last bit is taken.
- R6: `wlen_i` sets the bits per word: 2'b00 16, 2'b01 20, 2'b10 24, 2'b11 32. The word appears MSB-aligned in `smp_o`. Shorter words are zero-filled at the bottom, and the 8 LSBs of a 32-bit word are dropped.
- R7: With `bck_inv_i`=0, frame and data are taken on the rising edge of `bck_i`; with `bck_inv_i`=1, they are taken on the falling edge.
- R8: In I2S and left-aligned framing, if the frame level changes before the word is complete, the bits that did arrive are kept MSB-aligned and the rest are zero. At the 24-bit setting, a shorter sender word followed by zeros therefore comes out zero-filled.
- R9: After reset, `smp_o`=0, `smp_valid_o`=0 and `smp_right_o`=0. The first sampling edge only records the frame level. In the non-pulse framings, the slot in progress at the first observed frame-level change is not delivered. `smp_valid_o` is high for exactly one cycle per sample, and `smp_o` changes only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 2 | Framing select |
| lr_pol_i | input | 1 | Frame sense (pulse framing: late start) |
| bck_inv_i | input | 1 | Sample on falling bit-clock edge |
| wlen_i | input | 2 | Word length select |
| bck_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Serial frame clock |
| sdat_i | input | 1 | Serial data |
| smp_o | output | 24 | Normalised signed sample |
| smp_valid_o | output | 1 | One-cycle sample strobe |
| smp_right_o | output | 1 | Channel of the sample (1 = right) |

## Verification
The assertions assume that each half of the bit clock lasts several system-clock cycles, so that two sampling ticks can never fall on neighbouring cycles. They also assume that `wlen_i` and the other control fields stay fixed outside reset. The stimulus holds every bit-clock phase for four system clocks and changes frame and data only on the non-sampling edge. It applies each new control setting under reset, and it starts every stream with a short lead-in slot so that the first real boundary is seen cleanly.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  typedef logic [5:0] wbits_t;

  function automatic wbits_t word_bits(logic [1:0] wl, logic rj);
    case (wl)
      2'b00:   return 6'd16;
      2'b01:   return 6'd20;
      2'b10:   return 6'd24;
      default: return rj ? 6'd24 : 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/sar_bclk_sync.sv
module sar_bclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bck_inv_i,
  input  logic bck_i,
  input  logic lrck_i,
  input  logic sdat_i,
  output logic tick_o,
  output logic lr_o,
  output logic dat_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw, sync;
  logic            bck_q;

  assign raw = {bck_i, lrck_i, sdat_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign sync[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bck_q <= 1'b0;
    else         bck_q <= sync[2];
  end

  // rising edge when not inverted, falling edge when inverted
  assign tick_o = (sync[2] != bck_q) && (sync[2] != bck_inv_i);
  assign lr_o   = sync[1];
  assign dat_o  = sync[0];

  p_tick_spaced_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sar_deframer.sv
module sar_deframer
  import sar_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       fmt_i,
  input  logic             lr_pol_i,
  input  logic [1:0]       wlen_i,
  input  logic             tick_i,
  input  logic             lr_i,
  input  logic             dat_i,
  output logic             emit_o,
  output logic             emit_right_o,
  output logic [MAX_W-1:0] raw_o,
  output wbits_t           width_o,
  output logic             rj_o
);
  localparam int IDX_W = $clog2(MAX_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             started_q, synced_q, prev_lr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MAX_W-1:0] cap_q, sh_q, cap_base, cap_nx;

  logic             is_dsp, is_rj, lr_eff, boundary, in_left, in_right, last;
  logic [CNT_W-1:0] k, off, j, wext, pos;
  wbits_t           wbits;

  always_comb begin
    is_dsp   = (fmt_e'(fmt_i) == FMT_DSP);
    is_rj    = (fmt_e'(fmt_i) == FMT_RJ);
    wbits    = word_bits(wlen_i, is_rj);
    wext     = CNT_W'(wbits);
    lr_eff   = is_dsp ? lr_i : (lr_i ^ lr_pol_i);
    case (fmt_e'(fmt_i))
      FMT_I2S: off = CNT_W'(1);
      FMT_DSP: off = lr_pol_i ? CNT_W'(2) : CNT_W'(1);
      default: off = '0;
    endcase
    boundary = started_q &&
               (is_dsp ? (lr_eff && !prev_lr_q) : (lr_eff != prev_lr_q));
    if (boundary)              k = '0;
    else if (cnt_q == CNT_MAX) k = cnt_q;
    else                       k = cnt_q + 1'b1;
    j        = k - off;
    in_left  = (k >= off) && (j < wext);
    in_right = is_dsp && (k >= off) && (j >= wext) && (j < {wext[CNT_W-2:0], 1'b0});
    pos      = in_right ? (j - wext) : j;
    last     = (in_left || in_right) && (pos == wext - 1'b1);
    cap_base = boundary ? '0 : cap_q;
    cap_nx   = cap_base;
    if (in_left || in_right)
      cap_nx[IDX_W'(MAX_W-1) - pos[IDX_W-1:0]] = dat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q    <= 1'b0;
      synced_q     <= 1'b0;
      prev_lr_q    <= 1'b0;
      cnt_q        <= CNT_MAX;
      cap_q        <= '0;
      sh_q         <= '0;
      emit_o       <= 1'b0;
      emit_right_o <= 1'b0;
      raw_o        <= '0;
    end else begin
      emit_o <= 1'b0;
      if (tick_i) begin
        started_q <= 1'b1;
        prev_lr_q <= lr_eff;
        cnt_q     <= k;
        if (!is_dsp) begin
          cap_q <= cap_nx;
          if (boundary) begin
            synced_q     <= 1'b1;
            emit_o       <= synced_q;
            emit_right_o <= prev_lr_q;
            raw_o        <= is_rj ? sh_q : cap_q;
            sh_q         <= {{(MAX_W-1){1'b0}}, dat_i};
          end else begin
            sh_q <= {sh_q[MAX_W-2:0], dat_i};
          end
        end else if (last) begin
          emit_o       <= 1'b1;
          emit_right_o <= in_right;
          raw_o        <= cap_nx;
          cap_q        <= '0;
        end else begin
          cap_q <= cap_nx;
        end
      end
    end
  end

  assign width_o = wbits;
  assign rj_o    = is_rj;

  // a frame pulse can only emit within a bounded window after its start
  p_dsp_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_dsp && cnt_q == CNT_MAX) |-> !emit_o);
endmodule

// File: rtl/sar_align.sv
module sar_align
  import sar_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int OUT_W = 24
) (
  input  logic [MAX_W-1:0] raw_i,
  input  wbits_t           width_i,
  input  logic             rj_i,
  output logic [OUT_W-1:0] smp_o
);
  logic [MAX_W-1:0] aligned;
  wbits_t           sh_amt;

  always_comb begin
    sh_amt  = wbits_t'(MAX_W) - width_i;
    aligned = rj_i ? (raw_i << sh_amt) : raw_i;
    smp_o   = aligned[MAX_W-1 -: OUT_W];
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_W       = 32,
  parameter int OUT_W       = 24,
  parameter int CNT_W       = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       fmt_i,
  input  logic             lr_pol_i,
  input  logic             bck_inv_i,
  input  logic [1:0]       wlen_i,
  input  logic             bck_i,
  input  logic             lrck_i,
  input  logic             sdat_i,
  output logic [OUT_W-1:0] smp_o,
  output logic             smp_valid_o,
  output logic             smp_right_o
);
  logic             tick, lr_s, dat_s, emit, emit_right, rj;
  logic [MAX_W-1:0] raw;
  logic [OUT_W-1:0] aligned;
  wbits_t           width;

  sar_bclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .bck_inv_i, .bck_i, .lrck_i, .sdat_i,
    .tick_o(tick), .lr_o(lr_s), .dat_o(dat_s)
  );

  sar_deframer #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_deframe (
    .clk_i, .rst_ni, .fmt_i, .lr_pol_i, .wlen_i,
    .tick_i(tick), .lr_i(lr_s), .dat_i(dat_s),
    .emit_o(emit), .emit_right_o(emit_right), .raw_o(raw),
    .width_o(width), .rj_o(rj)
  );

  sar_align #(.MAX_W(MAX_W), .OUT_W(OUT_W)) u_align (
    .raw_i(raw), .width_i(width), .rj_i(rj), .smp_o(aligned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o       <= '0;
      smp_valid_o <= 1'b0;
      smp_right_o <= 1'b0;
    end else begin
      smp_valid_o <= emit;
      if (emit) begin
        smp_o       <= aligned;
        smp_right_o <= emit_right;
      end
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(smp_o) |-> smp_valid_o);
  p_pad16_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && wlen_i == 2'b00) |-> (smp_o[7:0] == 8'h00));
  p_pad20_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && wlen_i == 2'b01) |-> (smp_o[3:0] == 4'h0));
endmodule

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cfg_fmt = 2'b10;
  logic        cfg_pol = 1'b0;
  logic        cfg_inv = 1'b0;
  logic [1:0]  cfg_wl = 2'b10;
  logic        bck = 1'b0, lrck = 1'b0, sdat = 1'b0;
  logic [23:0] smp;
  logic        smp_valid, smp_right;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit prev_valid = 0;

  logic [23:0] q_val[$];
  bit          q_right[$];
  int          q_req[$];

  always #10 clk = ~clk;

  serial_audio_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(cfg_fmt), .lr_pol_i(cfg_pol),
    .bck_inv_i(cfg_inv), .wlen_i(cfg_wl), .bck_i(bck), .lrck_i(lrck),
    .sdat_i(sdat), .smp_o(smp), .smp_valid_o(smp_valid), .smp_right_o(smp_right)
  );

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && smp_valid) begin
      n_checks++;
      if (prev_valid) begin
        n_fail++;
        $display("FAIL R9 strobe wider than one cycle: actual 2 cycles expected 1");
      end else if (q_val.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected sample: actual %h/%0d expected none", smp, smp_right);
      end else begin
        logic [23:0] ev;
        bit er;
        int rq;
        ev = q_val.pop_front();
        er = q_right.pop_front();
        rq = q_req.pop_front();
        if (smp !== ev || smp_right !== er) begin
          n_fail++;
          $display("FAIL R%0d sample: actual %h/%0d expected %h/%0d", rq, smp, smp_right, ev, er);
        end
      end
    end
    prev_valid = rst_ni && smp_valid;
  end

  function automatic int eff_w();
    case (cfg_wl)
      2'b00:   return 16;
      2'b01:   return 20;
      2'b10:   return 24;
      default: return (cfg_fmt == 2'b00) ? 24 : 32;
    endcase
  endfunction

  task automatic apply_cfg(input logic [1:0] f, input logic p, input logic i, input logic [1:0] w);
    rst_ni = 1'b0;
    cfg_fmt = f; cfg_pol = p; cfg_inv = i; cfg_wl = w;
    bck = i; lrck = 1'b0; sdat = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic drive_bit(input logic lr, input logic d);
    bck = cfg_inv; lrck = lr; sdat = d;
    repeat (4) @(posedge clk);
    bck = ~cfg_inv;
    repeat (4) @(posedge clk);
  endtask

  task automatic push(input bit right, input logic [23:0] v, input int req);
    q_val.push_back(v); q_right.push_back(right); q_req.push_back(req);
  endtask

  // filler slot, nothing expected from it
  task automatic filler(input bit right, input int n);
    for (int t = 0; t < n; t++) drive_bit(right ^ cfg_pol, 1'b0);
  endtask

  task automatic std_slot(input bit right, input logic [31:0] word, input int tw,
                          input int len, input int req);
    logic [63:0] bits;
    logic [31:0] v;
    int off, w;
    bits = '0; v = '0;
    w = eff_w();
    off = (cfg_fmt == 2'b10) ? 1 : 0;
    if (cfg_fmt == 2'b00) begin
      for (int i = 0; i < tw; i++) bits[len - tw + i] = word[tw - 1 - i];
      for (int t = 0; t < len; t++) v = {v[30:0], bits[t]};
      v = v << (32 - w);
    end else begin
      for (int i = 0; i < tw; i++) if (off + i < len) bits[off + i] = word[tw - 1 - i];
      for (int i = 0; i < w; i++) if (off + i < len) v[31 - i] = bits[off + i];
    end
    push(right, v[31:8], req);
    for (int t = 0; t < len; t++) drive_bit(right ^ cfg_pol, bits[t]);
  endtask

  task automatic dsp_frame(input logic [31:0] lw, input logic [31:0] rw, input int req);
    logic [127:0] bits;
    logic [31:0] lv, rv;
    int off, w, n;
    bits = '0;
    w = eff_w();
    off = cfg_pol ? 2 : 1;
    for (int i = 0; i < w; i++) begin
      bits[off + i]     = lw[w - 1 - i];
      bits[off + w + i] = rw[w - 1 - i];
    end
    lv = lw << (32 - w);
    rv = rw << (32 - w);
    push(1'b0, lv[31:8], req);
    push(1'b1, rv[31:8], req);
    n = off + 2 * w + 2;
    for (int t = 0; t < n; t++) drive_bit(t == 0, bits[t]);
  endtask

  task automatic end_group(input string tag);
    repeat (40) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (q_val.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing samples: actual %0d pending expected 0", tag, q_val.size());
      q_val.delete(); q_right.delete(); q_req.delete();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (smp !== 24'h0 || smp_valid !== 1'b0 || smp_right !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset state: actual %h/%0d/%0d expected 000000/0/0", smp, smp_valid, smp_right);
    end

    // R2 R1: I2S 24 bit, normal sense
    apply_cfg(2'b10, 1'b0, 1'b0, 2'b10);
    filler(1'b1, 3);
    std_slot(1'b0, 32'h5A3C81, 24, 32, 2);
    std_slot(1'b1, 32'hA5C37E, 24, 32, 1);
    std_slot(1'b0, 32'h800001, 24, 32, 2);
    std_slot(1'b1, 32'h7FFFFF, 24, 32, 2);
    filler(1'b0, 3);
    end_group("R2");

    // R3 R6 R1: left aligned 16 bit, inverted frame sense
    apply_cfg(2'b01, 1'b1, 1'b0, 2'b00);
    filler(1'b1, 3);
    std_slot(1'b0, 32'hBEEF, 16, 20, 3);
    std_slot(1'b1, 32'h1234, 16, 20, 1);
    filler(1'b0, 3);
    end_group("R3");

    // R4 R7: right aligned 20 bit, falling-edge sampling
    apply_cfg(2'b00, 1'b0, 1'b1, 2'b01);
    filler(1'b1, 3);
    std_slot(1'b0, 32'hF0E1D, 20, 24, 7);
    std_slot(1'b1, 32'h0A5A5, 20, 24, 4);
    filler(1'b0, 3);
    end_group("R7");

    // R4: right aligned with 32-bit setting behaves as 24
    apply_cfg(2'b00, 1'b0, 1'b0, 2'b11);
    filler(1'b1, 3);
    std_slot(1'b0, 32'hC0FFEE, 24, 30, 4);
    std_slot(1'b1, 32'h13579B, 24, 30, 4);
    filler(1'b0, 3);
    end_group("R4");

    // R6: left aligned 32 bit drops low byte
    apply_cfg(2'b01, 1'b0, 1'b0, 2'b11);
    filler(1'b1, 3);
    std_slot(1'b0, 32'hDEADBEEF, 32, 32, 6);
    std_slot(1'b1, 32'h01234567, 32, 32, 6);
    filler(1'b0, 3);
    end_group("R6");

    // R8: 24-bit setting with a 16-bit sender
    apply_cfg(2'b10, 1'b0, 1'b0, 2'b10);
    filler(1'b1, 3);
    std_slot(1'b0, 32'h9ABC, 16, 26, 8);
    std_slot(1'b1, 32'h4321, 16, 26, 8);
    filler(1'b0, 3);
    end_group("R8");

    // R8: frame change before word complete
    apply_cfg(2'b10, 1'b0, 1'b0, 2'b10);
    filler(1'b1, 3);
    std_slot(1'b0, 32'hF6B3D5, 24, 11, 8);
    std_slot(1'b1, 32'h3C3C3C, 24, 28, 8);
    filler(1'b0, 3);
    end_group("R8b");

    // R5: pulse framed, early, 24 bit
    apply_cfg(2'b11, 1'b0, 1'b0, 2'b10);
    drive_bit(1'b0, 1'b0); drive_bit(1'b0, 1'b0);
    dsp_frame(32'h123456, 32'hFEDCBA, 5);
    dsp_frame(32'h800000, 32'h000001, 5);
    end_group("R5");

    // R5 R7: pulse framed, late, 16 bit, falling edge
    apply_cfg(2'b11, 1'b1, 1'b1, 2'b00);
    drive_bit(1'b0, 1'b0); drive_bit(1'b0, 1'b0);
    dsp_frame(32'hA1B2, 32'h5C6D, 5);
    dsp_frame(32'hFFFF, 32'h0001, 7);
    end_group("R5b");

    // R5 R6: pulse framed, 32 bit
    apply_cfg(2'b11, 1'b0, 1'b0, 2'b11);
    drive_bit(1'b0, 1'b0); drive_bit(1'b0, 1'b0);
    dsp_frame(32'h89ABCDEF, 32'h76543210, 6);
    end_group("R5c");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule